// File: doc/BRIEF.md
# Serial Register Control Port

This block lets an external host read and write a bank of 8-bit registers over four wires: a host-driven serial clock, an active-low select, a read/write level and one shared data line. Each frame carries an 8-bit address and then 8 data bits, both most significant bit first. The block samples all host lines in its own core clock domain. It drives the shared line only while it returns read data. The line is split at this boundary into an input, an output and an output enable, and a pad cell combines them.

The bank has `NREG` locations (96 by default). Indices `0..NRW-1` are writable configuration registers, and their contents leave the block on `cfg_q`. Indices `NRW..NREG-1` are read-only and show bytes supplied on `stat_in`. The register index is the address with its lowest bit dropped. Each accepted write also produces a one-cycle strobe that carries the index and the data.

The frame engine has five states:
- `ST_IDLE` waits for the synchronised select.
- `ST_ADDR` shifts in eight address bits. At the eighth bit it goes to `ST_RDATA` if the read/write line is high, and to `ST_WDATA` if it is low.
- `ST_RDATA` and `ST_WDATA` each move eight data bits and then go to `ST_DONE`.
- `ST_DONE` ignores further clocks.

Raising the select resets the engine to `ST_IDLE` asynchronously from any state.

Top module: `sreg_port`

## Requirements
- R1: In a write frame (read/write line low), the host sends 8 address bits and then 8 data bits, MSB first, each sampled on a rising serial clock edge. Register `addr[7:1]` then holds the data byte, and writable register k appears on `cfg_q[8k+7:8k]`.
- R2: Address bit 0 is ignored, so addresses 2k and 2k+1 reach the same register for both reads and writes.
- R3: In a read frame (read/write line high), the byte at index `addr[7:1]` is returned MSB first on `sd_o`. One bit is launched after each of rising edges 9 to 16, so the host can sample it on the following falling edge.
- R4: `sd_oe` stays low during the address phase and for the whole of a write frame. In a read frame it is high from rising edge 9 until the select goes high, and it drops as soon as the select is high.
- R5: Indices `NRW..NREG-1` are read-only. Reading index `NRW+j` returns `stat_in[8j+7:8j]`. A write to a read-only index changes nothing and raises no strobe.
- R6: Indices `NREG` and above read as 0x00, and writes to them change nothing.
- R7: A frame that ends (select high) before its 16th rising edge leaves every register unchanged and raises no strobe. The next frame is decoded again from its first bit.
- R8: Each committed write to a writable register raises `wr_stb` for exactly one core cycle, with `wr_idx` and `wr_data` giving the register and the new byte. `cfg_q` changes only in the cycle after a strobe.
- R9: After reset, `cfg_q` is all zero and `sd_oe` and `wr_stb` are low.
- R10: Serial clock edges after the 16th in the same frame are ignored. A write commits once with the first data byte, and a read keeps driving its last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Host serial clock, at most half the core clock rate |
| ser_csn | input | 1 | Active-low frame select |
| ser_rw | input | 1 | 1 = read frame, 0 = write frame |
| sd_i | input | 1 | Shared data line as seen by the pad input |
| sd_o | output | 1 | Read data bit towards the pad |
| sd_oe | output | 1 | Pad output enable for the shared line |
| stat_in | input | (NREG-NRW)*8 | Bytes shown by the read-only registers |
| cfg_q | output | NRW*8 | Contents of the writable registers |
| wr_stb | output | 1 | One-cycle pulse per committed write |
| wr_idx | output | 7 | Index of the written register |
| wr_data | output | 8 | Byte written |

## Verification
Writes and reads cover the first and last writable index, so an error at the top of the writable range shows up. Each write goes to an even address and is read back through the odd neighbour, or the reverse, which shows whether bit 0 is really dropped. Walking and alternating data bytes show whether the bit order is reversed or a bit is shifted. Reads at the first and last read-only index and at indices past the bank tell apart a write that wrongly lands, a wrong status byte and a decode that wraps around. Frames cut off at 4 and 12 bits and frames padded to 20 bits show whether a write commits too early, too late or more than once.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int FRAME_BITS = 8;
    localparam int IDX_W      = FRAME_BITS - 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_DONE
    } frame_st_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
#(
    parameter int NRW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csn_raw,
    input  logic             cs_act,
    input  logic             sclk_s,
    input  logic             sd_s,
    input  logic             rw_s,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sd_o,
    output logic             sd_oe,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output frame_st_t        st
);
    localparam logic [IDX_W:0]   NRW_L  = (IDX_W + 1)'(NRW);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_BITS - 1);

    frame_st_t              st_nx;
    logic                   sclk_d;
    logic                   rise;
    logic                   frm_rst_n;
    logic                   last_bit;
    logic                   commit;
    logic [CNT_W-1:0]       cnt;
    logic [FRAME_BITS-1:0]  shreg;
    logic [IDX_W-1:0]       idx_q;

    assign frm_rst_n = rst_n & ~csn_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise     = cs_act & sclk_s & ~sclk_d;
    assign last_bit = (cnt == LAST_C);
    assign commit   = (st == ST_WDATA) && rise && last_bit
                      && ({1'b0, idx_q} < NRW_L);
    assign rd_idx   = shreg[IDX_W-1:0];
    assign sd_o     = shreg[FRAME_BITS-1];

    // state register, cleared whenever the select is released
    always_ff @(posedge clk or negedge frm_rst_n) begin
        if (!frm_rst_n) st <= ST_IDLE;
        else            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (cs_act) st_nx = ST_ADDR;
            ST_ADDR:  if (rise && last_bit) st_nx = rw_s ? ST_RDATA : ST_WDATA;
            ST_RDATA: if (rise && last_bit) st_nx = ST_DONE;
            ST_WDATA: if (rise && last_bit) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_DONE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // per-frame datapath and pad enable
    always_ff @(posedge clk or negedge frm_rst_n) begin
        if (!frm_rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            idx_q <= '0;
            sd_oe <= 1'b0;
        end else if (rise) begin
            unique case (st)
                ST_ADDR: begin
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        idx_q <= shreg[IDX_W-1:0];
                        shreg <= rd_data;
                    end else begin
                        shreg <= {shreg[FRAME_BITS-2:0], sd_s};
                    end
                end
                ST_RDATA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == '0) sd_oe <= 1'b1;
                    else           shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
                ST_WDATA: begin
                    cnt   <= cnt + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], sd_s};
                end
                ST_IDLE, ST_DONE: ;
                default: ;
            endcase
        end
    end

    // write strobe survives an early select release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= commit;
            if (commit) begin
                wr_idx  <= idx_q;
                wr_data <= {shreg[FRAME_BITS-2:0], sd_s};
            end
        end
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int NREG = 96,
    parameter int NRW  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [7:0]               wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [7:0]               rd_data,
    input  logic [(NREG-NRW)*8-1:0]  stat_in,
    output logic [NRW*8-1:0]         cfg_q
);
    localparam int NRO = NREG - NRW;

    logic [7:0] regs [NRW];

    for (genvar g = 0; g < NRW; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
        assign cfg_q[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NRW; i++)
            if (rd_idx == IDX_W'(i)) rd_data = regs[i];
        for (int j = 0; j < NRO; j++)
            if (rd_idx == IDX_W'(NRW + j)) rd_data = stat_in[j*8 +: 8];
    end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int NREG = 96,
    parameter int NRW  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_csn,
    input  logic                     ser_rw,
    input  logic                     sd_i,
    output logic                     sd_o,
    output logic                     sd_oe,
    input  logic [(NREG-NRW)*8-1:0]  stat_in,
    output logic [NRW*8-1:0]         cfg_q,
    output logic                     wr_stb,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [7:0]               wr_data
);
    logic [3:0]       sync_q;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    frame_st_t        frame_st;

    sreg_sync #(.W(4), .INIT(4'b1000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_csn, ser_clk, sd_i, ser_rw}),
        .q     (sync_q)
    );

    sreg_frame #(.NRW(NRW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_raw (ser_csn),
        .cs_act  (~sync_q[3]),
        .sclk_s  (sync_q[2]),
        .sd_s    (sync_q[1]),
        .rw_s    (sync_q[0]),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .sd_o    (sd_o),
        .sd_oe   (sd_oe),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .st      (frame_st)
    );

    sreg_bank #(.NREG(NREG), .NRW(NRW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .stat_in (stat_in),
        .cfg_q   (cfg_q)
    );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
    import sreg_pkg::*;
#(
    parameter int NRW = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_csn,
    input logic               sd_oe,
    input logic               wr_stb,
    input logic [NRW*8-1:0]   cfg_q,
    input frame_st_t          frame_st
);
    p_oe_needs_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !ser_csn);

    p_oe_off_in_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st == ST_ADDR) |-> !sd_oe);

    p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_st == ST_WDATA) |-> !sd_oe);

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_q));
endmodule

bind sreg_port sreg_port_chk #(.NRW(NRW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_csn  (ser_csn),
    .sd_oe    (sd_oe),
    .wr_stb   (wr_stb),
    .cfg_q    (cfg_q),
    .frame_st (frame_st)
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
    localparam int NREG = 96;
    localparam int NRW  = 64;
    localparam int NRO  = NREG - NRW;
    localparam int HALF = 6;

    typedef struct {
        logic [6:0] idx;
        logic [7:0] dat;
        string      tag;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ser_clk = 1'b0;
    logic                ser_csn = 1'b1;
    logic                ser_rw = 1'b0;
    logic                sd_i = 1'b0;
    logic                sd_o, sd_oe, wr_stb;
    logic [NRO*8-1:0]    stat_in;
    logic [NRW*8-1:0]    cfg_q;
    logic [6:0]          wr_idx;
    logic [7:0]          wr_data;

    int total = 0;
    int bad   = 0;
    logic [7:0] mdl [NRW];
    item_t wr_q[$];
    item_t rd_q[$];
    item_t got_q[$];
    item_t mon_w, mon_e, mon_g;

    always #4 clk = ~clk;

    sreg_port #(.NREG(NREG), .NRW(NRW)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
        .ser_rw(ser_rw), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
        .stat_in(stat_in), .cfg_q(cfg_q), .wr_stb(wr_stb),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    function automatic logic [7:0] stat_byte(input int k);
        return 8'((k * 7) + 8'h31);
    endfunction

    function automatic logic [7:0] exp_read(input int idx);
        if (idx < NRW)  return mdl[idx];
        if (idx < NREG) return stat_byte(idx - NRW);
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares strobes and returned read bytes against the queues
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (wr_q.size() == 0) begin
                chk(1'b0, "R7 strobe without expected write", {wr_idx, wr_data}, 0);
            end else begin
                mon_w = wr_q.pop_front();
                chk(wr_idx == mon_w.idx && wr_data == mon_w.dat, mon_w.tag,
                    {wr_idx, wr_data}, {mon_w.idx, mon_w.dat});
            end
        end
        while (got_q.size() > 0 && rd_q.size() > 0) begin
            mon_g = got_q.pop_front();
            mon_e = rd_q.pop_front();
            chk(mon_g.dat == mon_e.dat, mon_e.tag, mon_g.dat, mon_e.dat);
        end
    end

    // driver: one frame of nbits serial clocks
    task automatic xfer(input bit rw, input logic [7:0] addr, input logic [7:0] wd,
                        input int nbits, input string tag);
        int         idx = int'(addr[7:1]);
        logic [7:0] rb = 8'h00;
        bit         oe_bad = 1'b0;
        item_t      it;
        it.idx = addr[7:1];
        it.tag = tag;
        if (nbits >= 16) begin
            if (rw) begin
                it.dat = exp_read(idx);
                rd_q.push_back(it);
            end else if (idx < NRW) begin
                it.dat = wd;
                wr_q.push_back(it);
            end
        end
        @(negedge clk);
        ser_rw  = rw;
        ser_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            sd_i = (b < 8) ? addr[7-b] : ((b < 16) ? wd[15-b] : 1'b1);
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
            if (rw && b >= 8) begin
                if (b < 16) rb[15-b] = sd_o;
                if (!sd_oe) oe_bad = 1'b1;
            end else if (sd_oe) begin
                oe_bad = 1'b1;
            end
        end
        repeat (HALF) @(negedge clk);
        if (rw && nbits > 16)
            chk(sd_o == exp_read(idx) [0], "R10 last bit held after extra clocks", sd_o, exp_read(idx) [0]);
        ser_csn = 1'b1;
        @(negedge clk);
        chk(!oe_bad, "R4 data line enable during frame", oe_bad, 0);
        chk(!sd_oe, "R4 line released after select high", sd_oe, 0);
        if (rw && nbits >= 16) begin
            it.dat = rb;
            got_q.push_back(it);
        end
        if (!rw && nbits >= 16 && idx < NRW) mdl[idx] = wd;
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < NRO; k++) stat_in[k*8 +: 8] = stat_byte(k);
        for (int k = 0; k < NRW; k++) mdl[k] = 8'h00;
        repeat (5) @(negedge clk);
        chk(sd_oe == 1'b0, "R9 reset enable low", sd_oe, 0);
        chk(wr_stb == 1'b0, "R9 reset strobe low", wr_stb, 0);
        chk(cfg_q == '0, "R9 reset registers zero", cfg_q[63:0], 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        xfer(1'b0, 8'h10, 8'hA5, 16, "R1 write index 8");
        chk(cfg_q[8*8 +: 8] == 8'hA5, "R1 cfg_q byte 8", cfg_q[8*8 +: 8], 8'hA5);
        xfer(1'b1, 8'h10, 8'h00, 16, "R3 read index 8");
        xfer(1'b1, 8'h11, 8'h00, 16, "R2 odd address reads index 8");
        xfer(1'b0, 8'h13, 8'h3C, 16, "R2 odd address writes index 9");
        xfer(1'b1, 8'h12, 8'h00, 16, "R2 even address reads index 9");
        chk(cfg_q[9*8 +: 8] == 8'h3C, "R2 cfg_q byte 9", cfg_q[9*8 +: 8], 8'h3C);

        xfer(1'b0, 8'h00, 8'h80, 16, "R8 write index 0 walking one");
        xfer(1'b0, 8'h7F, 8'h01, 16, "R8 write last writable index");
        xfer(1'b1, 8'h01, 8'h00, 16, "R3 read index 0");
        xfer(1'b1, 8'h7E, 8'h00, 16, "R3 read last writable index");
        xfer(1'b0, 8'h7E, 8'h55, 16, "R1 overwrite last writable index");
        xfer(1'b1, 8'h7F, 8'h00, 16, "R3 read alternating pattern");
        chk(cfg_q[63*8 +: 8] == 8'h55, "R1 cfg_q byte 63", cfg_q[63*8 +: 8], 8'h55);

        xfer(1'b1, 8'h80, 8'h00, 16, "R5 read first read-only index");
        xfer(1'b1, 8'hBF, 8'h00, 16, "R5 read last read-only index");
        xfer(1'b0, 8'h80, 8'hFF, 16, "R5 write to read-only index");
        xfer(1'b1, 8'h81, 8'h00, 16, "R5 read-only index unchanged");

        xfer(1'b1, 8'hC0, 8'h00, 16, "R6 read first index past bank");
        xfer(1'b1, 8'hFE, 8'h00, 16, "R6 read top index");
        xfer(1'b0, 8'hC2, 8'h77, 16, "R6 write past bank");
        xfer(1'b1, 8'hC3, 8'h00, 16, "R6 index past bank still zero");

        xfer(1'b0, 8'h10, 8'h11, 12, "R7 abort after 12 bits");
        xfer(1'b0, 8'h10, 8'h22, 4, "R7 abort after 4 bits");
        xfer(1'b1, 8'h10, 8'h00, 16, "R7 index 8 unchanged after aborts");
        chk(cfg_q[8*8 +: 8] == 8'hA5, "R7 cfg_q byte 8 kept", cfg_q[8*8 +: 8], 8'hA5);

        xfer(1'b0, 8'h20, 8'h5E, 20, "R10 padded write commits once");
        xfer(1'b1, 8'h21, 8'h00, 20, "R10 padded read");
        chk(cfg_q[16*8 +: 8] == 8'h5E, "R10 cfg_q byte 16", cfg_q[16*8 +: 8], 8'h5E);

        repeat (10) @(negedge clk);
        chk(wr_q.size() == 0, "R8 all expected strobes seen", wr_q.size(), 0);
        chk(rd_q.size() == 0, "R3 all reads compared", rd_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule